// File: doc/BRIEF.md
# Power-Controller Byte Handshake Sequencer

This block moves a single byte between the host side and a power-management microcontroller over a two-wire ready/acknowledge handshake. A `start_i` pulse with a direction (send or receive) kicks off the transfer. The sequencer first polls for the peer to signal readiness. It then waits for the peer's reply to its request, and after that runs a start phase and a finish phase that are specific to the chosen direction. A send drives the byte onto an outbound bus. A receive captures the inbound bus.

There are six wait points and each has its own watchdog window. The window length is set in clock cycles and restarts whenever a new wait begins. A transfer ends in exactly one of two ways. On success, `done_o` pulses for one cycle, together with a received-byte strobe if the transfer was a receive. On failure, `fault_o` pulses once and the block reports a fixed major code plus a 16-bit minor code that names the wait that expired. The request line to the peer stays high from the cycle after a start is accepted until the transfer ends.

Top module: `pmc_xfer_seq`

## Requirements
- R1: After synchronous reset the block is idle: `req_o`, `bus_drive_o`, `done_o`, `rx_valid_o` and `fault_o` are 0, and `fault_major_o`, `fault_minor_o`, `rx_byte_o` and `bus_out_o` are 0.
- R2: A `start_i` sampled high while idle latches `dir_i` (0 = send, 1 = receive) and `tx_byte_i`. While a transfer is running, `start_i`, `dir_i` and `tx_byte_i` have no effect.
- R3: If `peer_rdy_i` stays low for the whole window of the ready wait, the transfer fails with minor code 0xCD38.
- R4: Once ready is seen, the block waits for the reply, `peer_ack_i` high. If the reply does not come within the window, the minor code is 0xCD37.
- R5: In a send, the start phase waits for `peer_ack_i` low and the finish phase waits for `peer_ack_i` high. A window expiring in the start phase gives 0xCD36. A window expiring in the finish phase gives 0xCD35.
- R6: In a receive, the same two phases apply. A window expiring in the start phase gives 0xCD34. A window expiring in the finish phase gives 0xCD33.
- R7: A failure pulses `fault_o` for one cycle, sets `fault_major_o` to 0x14 and sets `fault_minor_o` to the code. Both code outputs hold their values until the next start is accepted, which clears them to 0.
- R8: Each wait samples its condition on at most `TIMEOUT_CYC` consecutive cycles, and the window restarts on entry to every wait. A condition seen on the last cycle of a window still advances the transfer. The fault appears on the clock edge that ends the last cycle of the window.
- R9: A completed finish phase pulses `done_o` for one cycle and drops `req_o` on the same edge. `done_o` and `fault_o` are never high together.
- R10: In a receive, `bus_in_i` is captured on the edge where the start phase sees `peer_ack_i` low. The captured byte appears on `rx_byte_o` with a one-cycle `rx_valid_o` that coincides with `done_o`.
- R11: `bus_drive_o` is high and `bus_out_o` carries the latched byte only during the start and finish phases of a send. At all other times `bus_drive_o` is 0 and `bus_out_o` is 0.
- R12: `req_o` rises on the edge after a start is accepted. It stays high until the edge that reports done or fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (accepted only while idle) |
| dir_i | input | 1 | 0 = send, 1 = receive |
| tx_byte_i | input | DATA_W | Byte to send |
| peer_rdy_i | input | 1 | Peer ready indication |
| peer_ack_i | input | 1 | Peer handshake line |
| bus_in_i | input | DATA_W | Inbound data bus |
| req_o | output | 1 | Handshake request to the peer |
| bus_drive_o | output | 1 | Outbound bus enable |
| bus_out_o | output | DATA_W | Outbound data bus |
| done_o | output | 1 | One-cycle success pulse |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_byte_o | output | DATA_W | Received byte |
| fault_o | output | 1 | One-cycle failure pulse |
| fault_major_o | output | 8 | Major code (0x14 after a failure) |
| fault_minor_o | output | 16 | Minor code naming the expired wait |

## Verification
The bench drives the ready wait right up to the edge of its window. It supplies ready on the final permitted cycle and then lets the reply wait expire by exactly one window. This catches a counter that is not reloaded between waits, since such a design would fault early or late with the wrong code. Each of the four direction-specific failures is provoked on its own, and the cycle count to the fault is measured, so a design that swaps start and finish codes or mixes up directions reports the wrong minor value. A start pulse with a new direction and byte is injected in the middle of a send; a design that relatches would drop the bus drive or change the outgoing byte. In the receive test the inbound bus changes right after the capture edge, which exposes a capture taken one cycle late.

// File: rtl/pmc_xfer_pkg.sv
package pmc_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_RDY  = 3'd1,
        ST_WAIT_REPLY= 3'd2,
        ST_TX_START  = 3'd3,
        ST_TX_FINISH = 3'd4,
        ST_RX_START  = 3'd5,
        ST_RX_FINISH = 3'd6
    } xfer_state_e;

    typedef enum logic {
        DIR_SEND = 1'b0,
        DIR_RECV = 1'b1
    } xfer_dir_e;

    localparam logic [7:0]  MAJOR_HANDSHAKE = 8'h14;
    localparam logic [15:0] E_NOT_READY     = 16'hCD38;
    localparam logic [15:0] E_NO_REPLY      = 16'hCD37;
    localparam logic [15:0] E_TX_NOSTART    = 16'hCD36;
    localparam logic [15:0] E_TX_NOFINISH   = 16'hCD35;
    localparam logic [15:0] E_RX_NOSTART    = 16'hCD34;
    localparam logic [15:0] E_RX_NOFINISH   = 16'hCD33;

    // Condition that ends the wait of a given state.
    function automatic logic wait_met(xfer_state_e s, logic rdy, logic ack);
        case (s)
            ST_WAIT_RDY:                 return rdy;
            ST_WAIT_REPLY:               return ack;
            ST_TX_START, ST_RX_START:    return !ack;
            ST_TX_FINISH, ST_RX_FINISH:  return ack;
            default:                     return 1'b0;
        endcase
    endfunction

    // Successor once the wait condition is met.
    function automatic xfer_state_e next_on_met(xfer_state_e s, xfer_dir_e d);
        case (s)
            ST_WAIT_RDY:   return ST_WAIT_REPLY;
            ST_WAIT_REPLY: return (d == DIR_RECV) ? ST_RX_START : ST_TX_START;
            ST_TX_START:   return ST_TX_FINISH;
            ST_RX_START:   return ST_RX_FINISH;
            default:       return ST_IDLE;
        endcase
    endfunction

    // Minor code for a wait that runs out of time.
    function automatic logic [15:0] code_for(xfer_state_e s);
        case (s)
            ST_WAIT_RDY:   return E_NOT_READY;
            ST_WAIT_REPLY: return E_NO_REPLY;
            ST_TX_START:   return E_TX_NOSTART;
            ST_TX_FINISH:  return E_TX_NOFINISH;
            ST_RX_START:   return E_RX_NOSTART;
            ST_RX_FINISH:  return E_RX_NOFINISH;
            default:       return 16'h0000;
        endcase
    endfunction

    function automatic logic is_finish(xfer_state_e s);
        return (s == ST_TX_FINISH) || (s == ST_RX_FINISH);
    endfunction

    function automatic logic known_code(logic [15:0] c);
        return (c == E_NOT_READY) || (c == E_NO_REPLY) || (c == E_TX_NOSTART) ||
               (c == E_TX_NOFINISH) || (c == E_RX_NOSTART) || (c == E_RX_NOFINISH);
    endfunction

endpackage

// File: rtl/pmc_wait_timer.sv
module pmc_wait_timer #(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] TOP = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= TOP;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R8: the window count never exceeds its programmed length
    assert_window_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOP);

    // R8: every load restarts the window at its full length
    assert_window_reload_R8: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == TOP));

endmodule

// File: rtl/pmc_xfer_data.sv
module pmc_xfer_data
    import pmc_xfer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              dir_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] bus_in_i,
    input  logic              drive_en_i,
    output xfer_dir_e         dir_o,
    output logic              bus_drive_o,
    output logic [DATA_W-1:0] bus_out_o,
    output logic [DATA_W-1:0] rx_byte_o
);
    xfer_dir_e         dir_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_SEND;
            tx_q  <= '0;
            rx_q  <= '0;
        end else begin
            if (accept_i) begin
                dir_q <= xfer_dir_e'(dir_i);
                tx_q  <= tx_byte_i;
            end
            if (capture_i) begin
                rx_q <= bus_in_i;
            end
        end
    end

    assign dir_o       = dir_q;
    assign bus_drive_o = drive_en_i;
    assign bus_out_o   = drive_en_i ? tx_q : '0;
    assign rx_byte_o   = rx_q;

    // R11: the outbound bus is only driven for a send
    assert_drive_send_only_R11: assert property (@(posedge clk) disable iff (rst)
        drive_en_i |-> (dir_q == DIR_SEND));

    // R2: the latched byte is stable while the bus is driven
    assert_tx_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (drive_en_i && $past(drive_en_i)) |-> $stable(tx_q));

endmodule

// File: rtl/pmc_xfer_fsm.sv
module pmc_xfer_fsm
    import pmc_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        peer_rdy_i,
    input  logic        peer_ack_i,
    input  xfer_dir_e   dir_i,
    input  logic        expired_i,
    output logic        accept_o,
    output logic        load_o,
    output logic        tick_o,
    output logic        capture_o,
    output logic        drive_en_o,
    output logic        req_o,
    output logic        done_o,
    output logic        rx_valid_o,
    output logic        fault_o,
    output logic [7:0]  fault_major_o,
    output logic [15:0] fault_minor_o
);
    xfer_state_e state_q;
    xfer_state_e nxt;
    logic        waiting;
    logic        met;

    assign waiting    = (state_q != ST_IDLE);
    assign met        = waiting && wait_met(state_q, peer_rdy_i, peer_ack_i);
    assign nxt        = next_on_met(state_q, dir_i);
    assign accept_o   = (state_q == ST_IDLE) && start_i;
    assign load_o     = accept_o || (met && (nxt != ST_IDLE));
    assign tick_o     = waiting && !met;
    assign capture_o  = met && (state_q == ST_RX_START);
    assign drive_en_o = (state_q == ST_TX_START) || (state_q == ST_TX_FINISH);
    assign req_o      = waiting;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            done_o        <= 1'b0;
            rx_valid_o    <= 1'b0;
            fault_o       <= 1'b0;
            fault_major_o <= '0;
            fault_minor_o <= '0;
        end else begin
            done_o     <= 1'b0;
            rx_valid_o <= 1'b0;
            fault_o    <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (start_i) begin
                    state_q       <= ST_WAIT_RDY;
                    fault_major_o <= '0;
                    fault_minor_o <= '0;
                end
            end else if (met) begin
                state_q <= nxt;
                if (is_finish(state_q)) begin
                    done_o     <= 1'b1;
                    rx_valid_o <= (state_q == ST_RX_FINISH);
                end
            end else if (expired_i) begin
                state_q       <= ST_IDLE;
                fault_o       <= 1'b1;
                fault_major_o <= MAJOR_HANDSHAKE;
                fault_minor_o <= code_for(state_q);
            end
        end
    end

    // R7: a fault always carries the major code and one of the six minor codes
    assert_fault_codes_R7: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (fault_major_o == MAJOR_HANDSHAKE) && known_code(fault_minor_o));

    // R9: success and failure are exclusive
    assert_outcome_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, fault_o}));

    // R12: request is released on the edge that reports the outcome
    assert_req_released_R12: assert property (@(posedge clk) disable iff (rst)
        (done_o || fault_o) |-> !req_o);

    // R12: request only rises after an accepted start
    assert_req_rise_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> $past(start_i));

    // R10: received-byte strobe only with a successful receive
    assert_rx_with_done_R10: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> done_o);

    // R7: minor code holds between outcomes while idle and not restarted
    assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q == ST_IDLE) && !$past(start_i)) |-> $stable(fault_minor_o));

endmodule

// File: rtl/pmc_xfer_seq.sv
module pmc_xfer_seq
    import pmc_xfer_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              peer_rdy_i,
    input  logic              peer_ack_i,
    input  logic [DATA_W-1:0] bus_in_i,
    output logic              req_o,
    output logic              bus_drive_o,
    output logic [DATA_W-1:0] bus_out_o,
    output logic              done_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              fault_o,
    output logic [7:0]        fault_major_o,
    output logic [15:0]       fault_minor_o
);
    logic      accept;
    logic      load;
    logic      tick;
    logic      capture;
    logic      drive_en;
    logic      expired;
    xfer_dir_e dir_q;

    pmc_xfer_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .peer_rdy_i    (peer_rdy_i),
        .peer_ack_i    (peer_ack_i),
        .dir_i         (dir_q),
        .expired_i     (expired),
        .accept_o      (accept),
        .load_o        (load),
        .tick_o        (tick),
        .capture_o     (capture),
        .drive_en_o    (drive_en),
        .req_o         (req_o),
        .done_o        (done_o),
        .rx_valid_o    (rx_valid_o),
        .fault_o       (fault_o),
        .fault_major_o (fault_major_o),
        .fault_minor_o (fault_minor_o)
    );

    pmc_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .tick_i    (tick),
        .expired_o (expired)
    );

    pmc_xfer_data #(.DATA_W(DATA_W)) u_data (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .dir_i       (dir_i),
        .tx_byte_i   (tx_byte_i),
        .capture_i   (capture),
        .bus_in_i    (bus_in_i),
        .drive_en_i  (drive_en),
        .dir_o       (dir_q),
        .bus_drive_o (bus_drive_o),
        .bus_out_o   (bus_out_o),
        .rx_byte_o   (rx_byte_o)
    );

endmodule

// File: tb/pmc_xfer_seq_test.sv
module pmc_xfer_seq_test;
    localparam int T = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        dir_i = 1'b0;
    logic [7:0]  tx_byte_i = '0;
    logic        peer_rdy_i = 1'b0;
    logic        peer_ack_i = 1'b0;
    logic [7:0]  bus_in_i = '0;
    logic        req_o, bus_drive_o, done_o, rx_valid_o, fault_o;
    logic [7:0]  bus_out_o, rx_byte_o, fault_major_o;
    logic [15:0] fault_minor_o;

    int n_vec = 0;
    int n_bad = 0;
    bit summary_done = 1'b0;

    always #4 clk = ~clk;

    pmc_xfer_seq #(.TIMEOUT_CYC(T), .DATA_W(8)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .dir_i(dir_i), .tx_byte_i(tx_byte_i),
        .peer_rdy_i(peer_rdy_i), .peer_ack_i(peer_ack_i), .bus_in_i(bus_in_i),
        .req_o(req_o), .bus_drive_o(bus_drive_o), .bus_out_o(bus_out_o),
        .done_o(done_o), .rx_valid_o(rx_valid_o), .rx_byte_o(rx_byte_o),
        .fault_o(fault_o), .fault_major_o(fault_major_o), .fault_minor_o(fault_minor_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic begin_xfer(input logic d, input logic [7:0] b);
        start_i = 1'b1; dir_i = d; tx_byte_i = b;
        step();
        start_i = 1'b0;
    endtask

    task automatic await_end(output int n);
        n = 0;
        while (!fault_o && !done_o && n < 100) begin
            step();
            n++;
        end
    endtask

    task automatic idle_peer();
        peer_rdy_i = 1'b0; peer_ack_i = 1'b0; bus_in_i = '0;
        step(); step();
    endtask

    task automatic t_reset();
        chk("R1 req", 32'(req_o), 0);
        chk("R1 drive/done/rxv/fault", {28'd0, bus_drive_o, done_o, rx_valid_o, fault_o}, 0);
        chk("R1 codes", {fault_major_o, fault_minor_o}, 0);
        chk("R1 data", {rx_byte_o, bus_out_o}, 0);
    endtask

    task automatic t_rdy_timeout();
        int n;
        peer_rdy_i = 1'b0; peer_ack_i = 1'b0;
        begin_xfer(1'b0, 8'h11);
        chk("R12 req after accept", 32'(req_o), 1);
        await_end(n);
        chk("R3 cycles to fault", n, T);
        chk("R3 minor", 32'(fault_minor_o), 32'hCD38);
        chk("R7 major", 32'(fault_major_o), 32'h14);
        chk("R12 req released on fault", 32'(req_o), 0);
        step();
        chk("R7 fault one cycle", 32'(fault_o), 0);
        chk("R7 minor held", 32'(fault_minor_o), 32'hCD38);
        idle_peer();
        chk("R7 minor still held", 32'(fault_minor_o), 32'hCD38);
    endtask

    task automatic t_send_ok();
        peer_rdy_i = 1'b1; peer_ack_i = 1'b1;
        begin_xfer(1'b0, 8'hA5);
        chk("R7 codes cleared on start", {fault_major_o, fault_minor_o}, 0);
        step();
        chk("R11 no drive before reply", 32'(bus_drive_o), 0);
        step();
        chk("R11 drive in send start", {bus_drive_o, bus_out_o}, {1'b1, 8'hA5});
        peer_ack_i = 1'b0;
        start_i = 1'b1; dir_i = 1'b1; tx_byte_i = 8'h00;
        step();
        start_i = 1'b0;
        chk("R2 busy start ignored", {bus_drive_o, bus_out_o}, {1'b1, 8'hA5});
        chk("R5 no fault mid send", 32'(fault_o), 0);
        peer_ack_i = 1'b1;
        step();
        chk("R9 done pulse", 32'(done_o), 1);
        chk("R9 req dropped with done", 32'(req_o), 0);
        chk("R11 drive off after send", {bus_drive_o, bus_out_o}, 0);
        chk("R10 no rx strobe on send", 32'(rx_valid_o), 0);
        step();
        chk("R9 done one cycle", 32'(done_o), 0);
        chk("R2 no restart from ignored start", 32'(req_o), 0);
        idle_peer();
    endtask

    task automatic t_recv_ok();
        peer_rdy_i = 1'b1; peer_ack_i = 1'b1;
        begin_xfer(1'b1, 8'h77);
        step(); step();
        chk("R11 no drive in receive", 32'(bus_drive_o), 0);
        peer_ack_i = 1'b0; bus_in_i = 8'h3C;
        step();
        bus_in_i = 8'hFF; peer_ack_i = 1'b1;
        chk("R11 no drive in receive finish", 32'(bus_drive_o), 0);
        step();
        chk("R10 done+rx_valid", {done_o, rx_valid_o}, 2'b11);
        chk("R10 rx byte captured at start edge", 32'(rx_byte_o), 32'h3C);
        step();
        chk("R10 rx_valid one cycle", 32'(rx_valid_o), 0);
        chk("R10 rx byte held", 32'(rx_byte_o), 32'h3C);
        idle_peer();
    endtask

    task automatic t_boundary_reload();
        int n;
        peer_rdy_i = 1'b0; peer_ack_i = 1'b0;
        begin_xfer(1'b0, 8'h5A);
        repeat (T-1) step();
        chk("R8 no fault before last ready cycle", 32'(fault_o), 0);
        peer_rdy_i = 1'b1;
        step();
        chk("R8 ready on last cycle accepted", {fault_o, req_o}, 2'b01);
        await_end(n);
        chk("R8 reply window reloaded", n, T);
        chk("R4 minor", 32'(fault_minor_o), 32'hCD37);
        idle_peer();
    endtask

    task automatic t_start_fail(input logic d, input logic [15:0] code, input string tag);
        int n;
        peer_rdy_i = 1'b1; peer_ack_i = 1'b1;
        begin_xfer(d, 8'h01);
        await_end(n);
        chk({tag, " cycles"}, n, T + 2);
        chk({tag, " minor"}, 32'(fault_minor_o), 32'(code));
        chk({tag, " major"}, 32'(fault_major_o), 32'h14);
        idle_peer();
    endtask

    task automatic t_finish_fail(input logic d, input logic [15:0] code, input string tag);
        int n;
        peer_rdy_i = 1'b1; peer_ack_i = 1'b1;
        begin_xfer(d, 8'h02);
        step(); step();
        peer_ack_i = 1'b0;
        await_end(n);
        chk({tag, " cycles"}, n, T + 1);
        chk({tag, " minor"}, 32'(fault_minor_o), 32'(code));
        chk({tag, " no done"}, 32'(done_o), 0);
        idle_peer();
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_rdy_timeout();
        t_send_ok();
        t_recv_ok();
        t_boundary_reload();
        t_start_fail(1'b0, 16'hCD36, "R5 send start");
        t_finish_fail(1'b0, 16'hCD35, "R5 send finish");
        t_start_fail(1'b1, 16'hCD34, "R6 recv start");
        t_finish_fail(1'b1, 16'hCD33, "R6 recv finish");
        finish_run();
    end

endmodule